// File: doc/BRIEF.md
# Inter-Processor Command Dispatcher

This block turns one write of a command word into one control action aimed at a single processor. Software writes the word with `wr_en` high. The block decodes the word and checks the target number against the count of processors present. It then raises a one-cycle pulse on the matching line of one of four per-processor output buses. The four actions are: post an interrupt vector, apply a power-on reset, halt the processor, or resume it.

The word carries three fields:
- the action code in bits 17:16;
- the target processor in bits 12:8;
- the vector in bits 5:0.

A reset command is honoured only when its vector equals the power-on reset vector, which is the parameter `POR_VEC` (default 1). Any other reset vector raises a one-cycle error pulse and touches no processor. The processors themselves perform the reset, halt and resume; this block only issues the requests.

Top module: `ipi_dispatch`

## Requirements
- R1: During and right after reset, every output bus, `post_vec` and `cmd_err` are zero.
- R2: Action code 0 raises `post_valid[target]` and places the vector on `post_vec` for the cycle after the write. When nothing is posted, `post_vec` reads zero.
- R3: Action code 1 with vector equal to `POR_VEC` has two effects. It raises `reset_req[target]` in the cycle after the write. It then raises `activate_req[target]` in the cycle after that.
- R4: Action code 1 with any other vector raises no reset and no activate. It raises `cmd_err` for the cycle after the write.
- R5: Action code 2 raises `halt_req[target]` for the cycle after the write.
- R6: Action code 3 raises `activate_req[target]` for the cycle after the write.
- R7: A write whose target is greater than or equal to `cpus_present`, or to `NCPU`, changes no output and raises no error.
- R8: Every request is a single-cycle pulse. Each write drives at most one line of each bus, and without a write nothing is raised except the activate that follows a reset.
- R9: Bits of the word outside the three fields have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Command word write strobe |
| wr_data | input | DATA_W | Command word |
| cpus_present | input | CPU_W+1 | Number of processors present |
| post_valid | output | NCPU | Interrupt post request, one bit per processor |
| post_vec | output | VEC_W | Vector of the current interrupt post |
| reset_req | output | NCPU | Power-on reset request per processor |
| halt_req | output | NCPU | Halt request per processor |
| activate_req | output | NCPU | Activate request per processor |
| cmd_err | output | 1 | Invalid reset vector pulse |

## Verification
All results except one are due in the first cycle after the clock edge that samples the write. That covers the post, the reset, the halt, the plain activate and the error pulse. The activate that follows a valid reset is due one cycle later.

The bench drives each write on a falling edge. It samples every output bus at the next falling edge and again one cycle later. It compares the first sample with the direct results and the second with the delayed activate, and expects all zeros wherever nothing is due. A back-to-back pair of writes checks that one command's delayed activate and the next command's pulse stay separate.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
  // command word field positions
  localparam int ACT_LSB = 16;
  localparam int ACT_W   = 2;
  localparam int TGT_LSB = 8;

  typedef enum logic [1:0] {
    ACT_POST   = 2'd0,
    ACT_RESET  = 2'd1,
    ACT_HALT   = 2'd2,
    ACT_RESUME = 2'd3
  } act_e;

  typedef struct packed {
    logic go_post;
    logic go_reset;
    logic go_halt;
    logic go_resume;
    logic bad_vec;
  } cmd_t;
endpackage

// File: rtl/ipi_decode.sv
module ipi_decode
  import ipi_pkg::*;
#(
  parameter int NCPU    = 32,
  parameter int CPU_W   = 5,
  parameter int VEC_W   = 6,
  parameter int DATA_W  = 32,
  parameter int POR_VEC = 1
) (
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [CPU_W:0]    cpus_present,
  output cmd_t              cmd,
  output logic [CPU_W-1:0]  tgt,
  output logic [VEC_W-1:0]  vec
);
  localparam logic [CPU_W:0] NCPU_L = (CPU_W+1)'(NCPU);

  act_e act;
  logic tgt_ok;

  always_comb begin
    act    = act_e'(wr_data[ACT_LSB +: ACT_W]);
    tgt    = wr_data[TGT_LSB +: CPU_W];
    vec    = wr_data[VEC_W-1:0];
    tgt_ok = wr_en && ({1'b0, tgt} < cpus_present) && ({1'b0, tgt} < NCPU_L);
    cmd    = '0;
    if (tgt_ok) begin
      unique case (act)
        ACT_POST:   cmd.go_post   = 1'b1;
        ACT_RESET:  begin
          if (vec == VEC_W'(POR_VEC)) cmd.go_reset = 1'b1;
          else                        cmd.bad_vec  = 1'b1;
        end
        ACT_HALT:   cmd.go_halt   = 1'b1;
        ACT_RESUME: cmd.go_resume = 1'b1;
        default:    cmd = '0;
      endcase
    end
  end
endmodule

// File: rtl/ipi_lane.sv
module ipi_lane
  import ipi_pkg::*;
#(
  parameter int CPU_W = 5,
  parameter int IDX   = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  cmd_t             cmd,
  input  logic [CPU_W-1:0] tgt,
  output logic             post_q,
  output logic             reset_q,
  output logic             halt_q,
  output logic             act_q
);
  logic sel;
  logic act_pend;

  assign sel = (tgt == CPU_W'(IDX));

  always_ff @(posedge clk) begin
    if (rst) begin
      post_q   <= 1'b0;
      reset_q  <= 1'b0;
      halt_q   <= 1'b0;
      act_q    <= 1'b0;
      act_pend <= 1'b0;
    end else begin
      post_q   <= sel & cmd.go_post;
      reset_q  <= sel & cmd.go_reset;
      halt_q   <= sel & cmd.go_halt;
      act_pend <= sel & cmd.go_reset;
      act_q    <= (sel & cmd.go_resume) | act_pend;
    end
  end
endmodule

// File: rtl/ipi_dispatch.sv
module ipi_dispatch
  import ipi_pkg::*;
#(
  parameter int NCPU    = 32,
  parameter int CPU_W   = 5,
  parameter int VEC_W   = 6,
  parameter int DATA_W  = 32,
  parameter int POR_VEC = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [CPU_W:0]    cpus_present,
  output logic [NCPU-1:0]   post_valid,
  output logic [VEC_W-1:0]  post_vec,
  output logic [NCPU-1:0]   reset_req,
  output logic [NCPU-1:0]   halt_req,
  output logic [NCPU-1:0]   activate_req,
  output logic              cmd_err
);
  cmd_t             cmd;
  logic [CPU_W-1:0] tgt;
  logic [VEC_W-1:0] vec;

  ipi_decode #(
    .NCPU(NCPU), .CPU_W(CPU_W), .VEC_W(VEC_W),
    .DATA_W(DATA_W), .POR_VEC(POR_VEC)
  ) u_dec (
    .wr_en(wr_en), .wr_data(wr_data), .cpus_present(cpus_present),
    .cmd(cmd), .tgt(tgt), .vec(vec)
  );

  for (genvar i = 0; i < NCPU; i++) begin : g_lane
    ipi_lane #(.CPU_W(CPU_W), .IDX(i)) u_lane (
      .clk(clk), .rst(rst), .cmd(cmd), .tgt(tgt),
      .post_q(post_valid[i]), .reset_q(reset_req[i]),
      .halt_q(halt_req[i]), .act_q(activate_req[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      post_vec <= '0;
      cmd_err  <= 1'b0;
    end else begin
      post_vec <= cmd.go_post ? vec : '0;
      cmd_err  <= cmd.bad_vec;
    end
  end
endmodule

// File: rtl/ipi_dispatch_chk.sv
module ipi_dispatch_chk #(
  parameter int NCPU    = 32,
  parameter int CPU_W   = 5,
  parameter int VEC_W   = 6,
  parameter int DATA_W  = 32,
  parameter int POR_VEC = 1
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic [CPU_W:0]    cpus_present,
  input logic [NCPU-1:0]   post_valid,
  input logic [VEC_W-1:0]  post_vec,
  input logic [NCPU-1:0]   reset_req,
  input logic [NCPU-1:0]   halt_req,
  input logic [NCPU-1:0]   activate_req,
  input logic              cmd_err
);
  // R1
  idle_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (post_valid == '0 && reset_req == '0 && halt_req == '0 &&
                    activate_req == '0 && post_vec == '0 && !cmd_err));
  // R2
  post_src_chk: assert property (@(posedge clk) disable iff (rst)
    (post_valid != '0) |-> ($past(wr_en) && $past(wr_data[17:16]) == 2'd0 &&
                            post_vec == $past(wr_data[VEC_W-1:0])));
  // R3
  reset_then_act_chk: assert property (@(posedge clk) disable iff (rst)
    (reset_req != '0) |=> ((activate_req & $past(reset_req)) == $past(reset_req)));
  // R4
  err_src_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_err |-> ($past(wr_en) && $past(wr_data[17:16]) == 2'd1 &&
                 $past(wr_data[VEC_W-1:0]) != VEC_W'(POR_VEC) && reset_req == '0));
  // R5
  halt_src_chk: assert property (@(posedge clk) disable iff (rst)
    (halt_req != '0) |-> ($past(wr_en) && $past(wr_data[17:16]) == 2'd2));
  // R6
  act_src_chk: assert property (@(posedge clk) disable iff (rst)
    (activate_req != '0) |-> (($past(wr_en) && $past(wr_data[17:16]) == 2'd3) ||
                              $past(reset_req) != '0));
  // R7
  halt_tgt_chk: assert property (@(posedge clk) disable iff (rst)
    (halt_req != '0) |-> ({1'b0, $past(wr_data[12:8])} < $past(cpus_present)));
  // R8
  one_line_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(post_valid) && $onehot0(reset_req) && $onehot0(halt_req));
endmodule

bind ipi_dispatch ipi_dispatch_chk #(
  .NCPU(NCPU), .CPU_W(CPU_W), .VEC_W(VEC_W), .DATA_W(DATA_W), .POR_VEC(POR_VEC)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
  .cpus_present(cpus_present), .post_valid(post_valid), .post_vec(post_vec),
  .reset_req(reset_req), .halt_req(halt_req), .activate_req(activate_req),
  .cmd_err(cmd_err)
);

// File: tb/ipi_dispatch_test.sv
module ipi_dispatch_test;
  localparam int NCPU = 8, CPU_W = 5, VEC_W = 6, DATA_W = 32, POR = 1;

  logic clk = 1'b0, rst = 1'b1, wr_en = 1'b0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [CPU_W:0] cpus_present = '0;
  logic [NCPU-1:0] post_valid, reset_req, halt_req, activate_req;
  logic [VEC_W-1:0] post_vec;
  logic cmd_err;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  ipi_dispatch #(.NCPU(NCPU), .CPU_W(CPU_W), .VEC_W(VEC_W),
                 .DATA_W(DATA_W), .POR_VEC(POR)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .cpus_present(cpus_present), .post_valid(post_valid), .post_vec(post_vec),
    .reset_req(reset_req), .halt_req(halt_req), .activate_req(activate_req),
    .cmd_err(cmd_err));

  function automatic logic [63:0] pk(input logic [NCPU-1:0] p, input logic [VEC_W-1:0] v,
      input logic [NCPU-1:0] r, input logic [NCPU-1:0] h, input logic [NCPU-1:0] a,
      input logic e);
    return 64'({p, v, r, h, a, e});
  endfunction

  function automatic logic [63:0] outs();
    return pk(post_valid, post_vec, reset_req, halt_req, activate_req, cmd_err);
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] word(input int t, input int c, input int v, input int junk);
    logic [DATA_W-1:0] w;
    w = DATA_W'(junk * 32'h9E37_79B1);
    w[17:16] = 2'(t);
    w[12:8]  = 5'(c);
    w[5:0]   = 6'(v);
    return w;
  endfunction

  // one write, sample one and two cycles later
  task automatic one_cmd(input int t, input int c, input int v, input int junk);
    logic ok;
    logic [NCPU-1:0] b;
    logic [63:0] e1, e2;
    string req;
    ok = (c < int'(cpus_present)) && (c < NCPU);
    b  = ok ? NCPU'(1) << c : '0;
    e1 = pk((t == 0) ? b : '0, (ok && t == 0) ? VEC_W'(v) : '0,
            (t == 1 && v == POR) ? b : '0, (t == 2) ? b : '0, (t == 3) ? b : '0,
            ok && t == 1 && v != POR);
    e2 = pk('0, '0, '0, '0, (t == 1 && v == POR) ? b : '0, 1'b0);
    if (!ok) req = "R7";
    else if (t == 0) req = "R2";
    else if (t == 1) req = (v == POR) ? "R3" : "R4";
    else if (t == 2) req = "R5";
    else req = "R6";
    if (junk != 0 && ok) req = {req, "/R9"};
    @(negedge clk);
    wr_en = 1'b1; wr_data = word(t, c, v, junk);
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
    check(req, outs(), e1);
    @(negedge clk);
    check({req, "/R8"}, outs(), e2);
  endtask

  initial begin
    int p_list[4] = '{0, 1, 5, 8};
    int v_list[5] = '{0, 1, 2, 37, 63};
    // R1
    repeat (3) @(negedge clk);
    check("R1", outs(), 64'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1", outs(), 64'd0);
    foreach (p_list[pi]) begin
      cpus_present = (CPU_W+1)'(p_list[pi]);
      for (int c = 0; c < 32; c++)
        for (int t = 0; t < 4; t++)
          foreach (v_list[vi]) one_cmd(t, c, v_list[vi], (c + t + vi) % 3);
    end
    // R8: back-to-back reset on cpu 2 then post on cpu 4
    cpus_present = 7'(8);
    @(negedge clk);
    wr_en = 1'b1; wr_data = word(1, 2, POR, 0);
    @(negedge clk);
    wr_data = word(0, 4, 9, 0);
    check("R3", outs(), pk('0, '0, 8'h04, '0, '0, 1'b0));
    @(negedge clk);
    wr_en = 1'b0;
    check("R8", outs(), pk(8'h10, 6'd9, '0, '0, 8'h04, 1'b0));
    @(negedge clk);
    check("R8", outs(), 64'd0);
    // R1: reset mid-stream clears a pending pulse
    wr_en = 1'b1; wr_data = word(3, 0, 0, 0);
    @(negedge clk);
    wr_en = 1'b0; rst = 1'b1;
    @(negedge clk);
    check("R1", outs(), 64'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 150000);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule